// File: doc/BRIEF.md
# Byte-Wide Ultraviolet-Erasable Memory Model

This block is a cycle-level, synthesizable model of a byte-wide, ultraviolet-erasable programmable read-only memory. It is intended as a test target on a chip or in an emulation fabric, standing in for a real device. Two active-low controls gate the part: a select (`sel_n`) and a drive enable (`drv_n`). Two flags stand for the high-voltage conditions. `hv_supply` marks the raised programming supply and `hv_idpin` marks the raised level on address bit 9. The tri-state data bus is split into `bus_in`, `bus_out` and `bus_drv`.

The model decodes these modes: reading, output disable, standby, programming, program verify, program inhibit and an identifier mode. The storage behaves as it does in the real device. A blank array reads all ones, and a programming pulse can only clear bits. The `wipe` input stands in for ultraviolet exposure and returns every cell to the blank state. Every output is registered. A change on the inputs during one cycle shows at the outputs after the next rising clock edge. The bus is a plain tri-state bus with no handshake, so no back-pressure applies.

Top module: `uvrom_model`

## Requirements
- R1: After reset, and one cycle after `wipe` is high for a clock edge, every byte reads 8'hFF. During reset `bus_drv` and `id_fault` are 0.
- R2: A programming pulse stores the old byte AND `bus_in`. Bits can only go from 1 to 0, and programming 8'hFF leaves a byte unchanged.
- R3: With `sel_n`=0, `drv_n`=0 and `hv_idpin`=0, the outputs after the next edge are `bus_drv`=1 and `bus_out` equal to the byte at `addr`.
- R4: With `sel_n`=1 and `hv_supply`=0 (standby), `bus_drv` is 0 after the next edge, whatever `drv_n` is.
- R5: With `sel_n`=0 and `drv_n`=1 (output disable, or programming), `bus_drv` is 0 after the next edge.
- R6: A program pulse is written when `sel_n` rises. The cycle before must have had `sel_n`=0, `drv_n`=1 and `hv_supply`=1, and the rising cycle must still have `drv_n`=1 and `hv_supply`=1. The write uses the `addr` and `bus_in` of the rising cycle.
- R7: With `hv_supply`=1, `sel_n`=1 and `drv_n`=1 (program inhibit), `bus_drv` is 0 and no byte changes.
- R8: With `hv_supply`=1, `sel_n`=1 and `drv_n`=0 (program verify), `bus_drv` is 1 and `bus_out` is the byte at `addr`.
- R9: With `hv_idpin`=1, `sel_n`=0 and `drv_n`=0, and every address bit other than bits 0 and 9 at 0, `bus_out` is 8'h01 when `addr[0]`=0 and 8'h10 when `addr[0]`=1. `id_fault` is 0, and both codes have odd parity over all 8 bits, with bit 7 as the parity bit.
- R10: In identifier mode, if any address bit other than bits 0 and 9 is 1, `bus_out` is 8'h00, `bus_drv` is 1 and `id_fault` is 1. In every other mode `id_fault` is 0.
- R11: A `sel_n` low-to-high pulse with `hv_supply`=0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; blanks the array |
| sel_n | input | 1 | Active-low select; its rising edge ends a program pulse |
| drv_n | input | 1 | Active-low output drive enable |
| hv_supply | input | 1 | High-voltage programming supply present |
| hv_idpin | input | 1 | High-voltage identifier level on address bit 9 |
| wipe | input | 1 | Erase: sets every cell to 1 |
| addr | input | ADDR_W | Byte address |
| bus_in | input | 8 | Data into the part during programming |
| bus_out | output | 8 | Data out of the part, valid when bus_drv is 1 |
| bus_drv | output | 1 | Output drive enable of the data bus |
| id_fault | output | 1 | Identifier read with stray address bits set |

## Verification
A wrong internal state here shows up one cycle later on `bus_drv` or `bus_out`. If the mode decode is wrong, the bus drives when it should float, or floats when it should drive, after the next edge. A corrupted array or a bad write gate stays hidden until that address is read back. For that reason the sequence reads back each programmed address, and each address that was pulsed without effect, right after the pulse. An identifier-path fault shows as a wrong code or a stuck `id_fault` on the first identifier read.

// File: rtl/uvrom_pkg.sv
`timescale 1ns/1ps
package uvrom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_FLOAT  = 3'd0,
    MD_READ   = 3'd1,
    MD_VERIFY = 3'd2,
    MD_PROG   = 3'd3,
    MD_IDENT  = 3'd4
  } mode_e;

  // seven payload bits plus a top bit chosen so the byte has odd parity
  function automatic logic [BYTE_W-1:0] odd_code(input logic [BYTE_W-2:0] low);
    return {~(^low), low};
  endfunction
endpackage

// File: rtl/uvrom_decode.sv
`timescale 1ns/1ps
module uvrom_decode
  import uvrom_pkg::*;
(
  input  logic  sel_n,
  input  logic  drv_n,
  input  logic  hv_supply,
  input  logic  hv_idpin,
  output mode_e mode
);
  always_comb begin
    mode = MD_FLOAT;
    if (!sel_n) begin
      if (drv_n) mode = hv_supply ? MD_PROG : MD_FLOAT;
      else       mode = hv_idpin ? MD_IDENT : MD_READ;
    end else if (hv_supply && !drv_n) begin
      mode = MD_VERIFY;
    end
  end
endmodule

// File: rtl/uvrom_cells.sv
`timescale 1ns/1ps
module uvrom_cells #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  assign rd_data = cell_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (wr_en) begin
      cell_q[addr] <= cell_q[addr] & wr_data;
    end
  end

  // R2: a write never sets a bit that was clear before it
  p_only_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wipe) |=> ((cell_q[$past(addr)] & ~$past(rd_data)) == '0));

  // R1: erase leaves the first and last cell blank
  p_wipe_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> ((&cell_q[0]) && (&cell_q[DEPTH-1])));
endmodule

// File: rtl/uvrom_ident.sv
`timescale 1ns/1ps
module uvrom_ident
  import uvrom_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          HV_BIT  = 9,
  parameter logic [6:0]  MAKER   = 7'h01,
  parameter logic [6:0]  PART    = 7'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] code,
  output logic              stray
);
  logic [ADDR_W-1:0] care;

  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
      if (i == 0 || i == HV_BIT) begin : g_skip
        assign care[i] = 1'b0;
      end else begin : g_chk
        assign care[i] = addr[i];
      end
    end
  endgenerate

  assign stray = |care;
  assign code  = addr[0] ? odd_code(PART) : odd_code(MAKER);
endmodule

// File: rtl/uvrom_model.sv
`timescale 1ns/1ps
module uvrom_model
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              drv_n,
  input  logic              hv_supply,
  input  logic              hv_idpin,
  input  logic              wipe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        bus_in,
  output logic [7:0]        bus_out,
  output logic              bus_drv,
  output logic              id_fault
);
  mode_e             mode;
  logic [BYTE_W-1:0] cell_rd;
  logic [BYTE_W-1:0] id_code;
  logic              id_stray;
  logic              armed_q;
  logic              ident_q;
  logic              wr_en;

  uvrom_decode u_dec (
    .sel_n(sel_n), .drv_n(drv_n), .hv_supply(hv_supply),
    .hv_idpin(hv_idpin), .mode(mode)
  );

  uvrom_ident #(.ADDR_W(ADDR_W)) u_id (
    .addr(addr), .code(id_code), .stray(id_stray)
  );

  uvrom_cells #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .wr_en(wr_en),
    .addr(addr), .wr_data(bus_in), .rd_data(cell_rd)
  );

  // pulse ends on select rising while program conditions still hold
  assign wr_en = armed_q && sel_n && drv_n && hv_supply && !wipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      ident_q  <= 1'b0;
      bus_drv  <= 1'b0;
      bus_out  <= '0;
      id_fault <= 1'b0;
    end else begin
      armed_q <= (mode == MD_PROG);
      ident_q <= (mode == MD_IDENT);
      unique case (mode)
        MD_READ, MD_VERIFY: begin
          bus_drv  <= 1'b1;
          bus_out  <= cell_rd;
          id_fault <= 1'b0;
        end
        MD_IDENT: begin
          bus_drv  <= 1'b1;
          bus_out  <= id_stray ? '0 : id_code;
          id_fault <= id_stray;
        end
        default: begin
          bus_drv  <= 1'b0;
          bus_out  <= '0;
          id_fault <= 1'b0;
        end
      endcase
    end
  end

  p_standby_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !hv_supply) |=> !bus_drv);

  p_disable_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && drv_n) |=> !bus_drv);

  p_id_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_q && !id_fault) |-> (^bus_out));

  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_fault |-> (bus_drv && bus_out == 8'h00 && ident_q));

  p_no_write_low_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_supply |-> !wr_en);
endmodule

// File: tb/uvrom_model_tb.sv
`timescale 1ns/1ps
module uvrom_model_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       drv_n = 1'b1;
  logic       hv_supply = 1'b0;
  logic       hv_idpin = 1'b0;
  logic       wipe = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_drv;
  logic       id_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit         q_chk [$];
  bit         q_drv [$];
  logic [7:0] q_dat [$];
  bit         q_flt [$];
  int         q_req [$];

  always #10 clk = ~clk;

  uvrom_model #(.ADDR_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .drv_n(drv_n),
    .hv_supply(hv_supply), .hv_idpin(hv_idpin), .wipe(wipe),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drv(bus_drv), .id_fault(id_fault)
  );

  // driver: one call per cycle, pushes the expected outputs of that cycle
  task automatic cyc(input bit s, input bit d, input bit hv, input bit idp,
                     input bit w, input logic [9:0] a, input logic [7:0] din,
                     input bit chk, input bit edrv, input logic [7:0] edat,
                     input bit eflt, input int req);
    @(negedge clk);
    sel_n = s; drv_n = d; hv_supply = hv; hv_idpin = idp; wipe = w;
    addr = a; bus_in = din;
    q_chk.push_back(chk); q_drv.push_back(edrv); q_dat.push_back(edat);
    q_flt.push_back(eflt); q_req.push_back(req);
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] e, input int req);
    cyc(0, 0, 0, 0, 0, a, 8'h00, 1, 1, e, 0, req);
  endtask

  task automatic prog(input logic [9:0] a, input logic [7:0] din, input bit hv, input int req);
    cyc(0, 1, hv, 0, 0, a, din, 1, 0, 8'h00, 0, req);  // bus floats while pulsing
    cyc(1, 1, hv, 0, 0, a, din, 0, 0, 8'h00, 0, req);
  endtask

  // monitor: pops one expectation per edge and compares mid-cycle
  always @(posedge clk) begin
    #5;
    if (q_chk.size() > 0) begin
      bit c; bit ed; logic [7:0] ev; bit ef; int r;
      c = q_chk.pop_front(); ed = q_drv.pop_front(); ev = q_dat.pop_front();
      ef = q_flt.pop_front(); r = q_req.pop_front();
      if (c) begin
        checks++;
        if (bus_drv !== ed || id_fault !== ef || (ed && bus_out !== ev)) begin
          errors++;
          $display("FAIL R%0d: drv=%b out=%h fault=%b expected drv=%b out=%h fault=%b",
                   r, bus_drv, bus_out, id_fault, ed, ev, ef);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (bus_drv !== 1'b0 || id_fault !== 1'b0) begin
      errors++;
      $display("FAIL R1: drv=%b fault=%b expected drv=0 fault=0", bus_drv, id_fault);
    end
    rst_n = 1'b1;

    // R1 blank array after reset
    rd(10'h000, 8'hFF, 1);
    rd(10'h3FF, 8'hFF, 1);
    // R6 program pulse then R3 read back
    prog(10'h005, 8'hA5, 1, 6);
    rd(10'h005, 8'hA5, 3);
    rd(10'h006, 8'hFF, 3);
    // R2 second pulse ANDs, all-ones pulse changes nothing
    prog(10'h005, 8'h0F, 1, 2);
    rd(10'h005, 8'h05, 2);
    prog(10'h005, 8'hFF, 1, 2);
    rd(10'h005, 8'h05, 2);
    // R4 standby with either drive enable
    cyc(1, 0, 0, 0, 0, 10'h005, 8'h00, 1, 0, 8'h00, 0, 4);
    cyc(1, 1, 0, 0, 0, 10'h005, 8'h00, 1, 0, 8'h00, 0, 4);
    // R5 output disable
    cyc(0, 1, 0, 0, 0, 10'h005, 8'h00, 1, 0, 8'h00, 0, 5);
    // R8 program verify drives stored byte
    cyc(1, 0, 1, 0, 0, 10'h005, 8'h00, 1, 1, 8'h05, 0, 8);
    // R7 inhibit: floats, no write while select stays high
    cyc(1, 1, 1, 0, 0, 10'h005, 8'h00, 1, 0, 8'h00, 0, 7);
    cyc(1, 1, 1, 0, 0, 10'h005, 8'h00, 1, 0, 8'h00, 0, 7);
    rd(10'h005, 8'h05, 7);
    // R11 pulse without high supply writes nothing
    prog(10'h006, 8'h00, 0, 11);
    rd(10'h006, 8'hFF, 11);
    // R9 identifier codes, bit 9 logic level ignored
    cyc(0, 0, 0, 1, 0, 10'h000, 8'h00, 1, 1, 8'h01, 0, 9);
    cyc(0, 0, 0, 1, 0, 10'h001, 8'h00, 1, 1, 8'h10, 0, 9);
    cyc(0, 0, 0, 1, 0, 10'h200, 8'h00, 1, 1, 8'h01, 0, 9);
    // R10 stray address bits in identifier mode
    cyc(0, 0, 0, 1, 0, 10'h004, 8'h00, 1, 1, 8'h00, 1, 10);
    cyc(0, 0, 0, 1, 0, 10'h101, 8'h00, 1, 1, 8'h00, 1, 10);
    rd(10'h004, 8'hFF, 10);
    // R1 erase restores blank
    cyc(1, 1, 0, 0, 1, 10'h000, 8'h00, 1, 0, 8'h00, 0, 1);
    rd(10'h005, 8'hFF, 1);
    cyc(1, 1, 0, 0, 0, 10'h000, 8'h00, 0, 0, 8'h00, 0, 1);
    repeat (3) @(posedge clk);
    #7;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule